// File: doc/BRIEF.md
# Dual-Channel PWM Slice with Fractional Rate Divider

This block is one pulse-width modulation slice. A 16-bit counter steps through a programmable range and is compared against two independent levels, one for each of the two outputs. An output is active while the counter sits below its level, so the active fraction of the period follows the programmed level. Each output has its own polarity. The counter can sawtooth (count up, then restart from zero) or run phase-correct (count up to the limit, then back down to zero), which centres the pulses in the period.

The counting rate comes from a fractional divider with an 8-bit integer part and a 4-bit fraction. Its input events are either every system clock or activity on the `pin_b` input: its high level, its rising edges or its falling edges. This lets the slice act as a gated or edge counter. The compare levels and the limit are held in shadow registers. While the slice runs they reach the comparator only at the period boundary, so a new duty cycle never produces a torn period. A sticky flag marks each period boundary and can raise an interrupt. Two phase inputs insert or drop one count to shift the waveform.

Software programs the slice through a single-cycle write port with six word addresses.

Top module: `pwm_slice`

## Requirements
- R1: `out_a` is 1 while `count` < the active compare level A, and `out_b` likewise against level B. Setting CTRL bit 2 (A) or bit 3 (B) inverts that output. Out of reset both levels are 0 and both outputs are 0.
- R2: With CTRL bit 1 = 0, each step adds 1 to the counter. A step taken at the active limit (or above it) returns the counter to 0. After reset the limit is 0xFFFF and the counter is 0.
- R3: With CTRL bit 1 = 1, the counter rises to the limit and then falls back to 0, so the period is twice the limit in steps. At the limit, the next step gives limit-1.
- R4: The DIV register (address 1) holds D in sixteenths: bits [11:4] are the integer part and bits [3:0] the fraction. Over any run starting from a cleared accumulator, E input events produce floor(16*E/D) steps. A D below 16 acts as 16. The reset value is 16.
- R5: CTRL bits [5:4] select the event source. 0 means every clock. 1 means each clock on which `pin_b` is high. `pin_b` passes through a two-flop synchronizer first.
- R6: CTRL mode 2 makes each rising edge of `pin_b` one event. Mode 3 makes each falling edge one event.
- R7: Writes to CMP (address 2: A in [15:0], B in [31:16]) and TOP (address 3) go to shadow registers. While CTRL bit 0 (run) is 1, the shadows are copied to the active registers only on a period-boundary step. While run is 0, the copy is made every cycle.
- R8: A sticky flag is set on the step that returns the counter to 0: the limit-to-0 restart in sawtooth mode, or the 1-to-0 step in phase-correct mode. `irq` equals the flag AND CTRL bit 6.
- R9: Writing address 4 with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged. If a set and a clear fall in the same cycle, the set wins.
- R10: While running, a cycle with `phase_adv` high makes a step even when the divider does not fire. A cycle with `phase_ret` high drops the divider's step for that cycle.
- R11: A write to address 5 loads the counter with bits [15:0], clears the divider accumulator and restores the up direction.
- R12: While run is 0, the counter and divider hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| pin_b | input | 1 | External event input (asynchronous) |
| phase_adv | input | 1 | Insert one count step this cycle |
| phase_ret | input | 1 | Drop this cycle's divider step |
| out_a | output | 1 | Channel A waveform |
| out_b | output | 1 | Channel B waveform |
| irq | output | 1 | Period-boundary interrupt (flag AND enable) |
| count | output | 16 | Current counter value |

## Verification
On every cycle, assertions check the following. The counter never moves without a step or a load. A sawtooth step at the limit lands on zero. A phase-correct step at the limit turns the count down by one. The flag stays set until it is cleared. The active compare levels do not change while the slice runs between boundaries. No step is issued while the slice is stopped, and the divider never fires without an event. The bench scenarios are what show the arithmetic of the fractional divider over long windows, the counts produced by gated and edge inputs through the synchronizer, the deferral of duty and limit changes to the next boundary, the exact cycle on which the interrupt rises in each counting mode, and the full 65536-step period that follows reset.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

    typedef enum logic [1:0] {
        DM_FREE  = 2'd0,
        DM_LEVEL = 2'd1,
        DM_RISE  = 2'd2,
        DM_FALL  = 2'd3
    } div_mode_e;

    // packed MSB first: irq_en is bit 6, run is bit 0
    typedef struct packed {
        logic      irq_en;
        div_mode_e mode;
        logic      inv_b;
        logic      inv_a;
        logic      phase;
        logic      run;
    } ctrl_t;

    localparam int unsigned A_CTRL = 0;
    localparam int unsigned A_DIV  = 1;
    localparam int unsigned A_CMP  = 2;
    localparam int unsigned A_TOP  = 3;
    localparam int unsigned A_IRQ  = 4;
    localparam int unsigned A_CNT  = 5;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div_val,
    output logic [CNT_W-1:0]  cmp_a_sh,
    output logic [CNT_W-1:0]  cmp_b_sh,
    output logic [CNT_W-1:0]  top_sh,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wval,
    output logic              irq_clr
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(1) << FRAC_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cmp_a;
        logic [CNT_W-1:0] cmp_b;
        logic [CNT_W-1:0] top;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        cnt_wr   = 1'b0;
        irq_clr  = 1'b0;
        cnt_wval = cfg_wdata[CNT_W-1:0];
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_W'(A_CTRL): r_d.ctrl = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                ADDR_W'(A_DIV):  r_d.div  = cfg_wdata[DIV_W-1:0];
                ADDR_W'(A_CMP): begin
                    r_d.cmp_a = cfg_wdata[CNT_W-1:0];
                    r_d.cmp_b = cfg_wdata[2*CNT_W-1:CNT_W];
                end
                ADDR_W'(A_TOP):  r_d.top  = cfg_wdata[CNT_W-1:0];
                ADDR_W'(A_IRQ):  irq_clr  = cfg_wdata[0];
                ADDR_W'(A_CNT):  cnt_wr   = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl  <= '0;
            r_q.div   <= DIV_RST;
            r_q.cmp_a <= '0;
            r_q.cmp_b <= '0;
            r_q.top   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl     = r_q.ctrl;
    assign div_val  = r_q.div;
    assign cmp_a_sh = r_q.cmp_a;
    assign cmp_b_sh = r_q.cmp_b;
    assign top_sh   = r_q.top;

endmodule

// File: rtl/pwm_rate_gen.sv
module pwm_rate_gen
    import pwm_slice_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  div_mode_e        mode,
    input  logic [DIV_W-1:0] div_val,
    input  logic             pin_b,
    input  logic             acc_clr,
    input  logic             adv,
    input  logic             ret,
    output logic             step
);
    localparam int ACC_W = DIV_W + 1;
    localparam int SH_W  = SYNC_N + 1;
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1) << FRAC_W;

    typedef struct packed {
        logic [SH_W-1:0]  sync;
        logic [ACC_W-1:0] acc;
    } rg_t;

    rg_t st_d, st_q;

    logic             pin_now, pin_old, evt, pulse;
    logic [DIV_W-1:0] div_eff;
    logic [ACC_W-1:0] acc_sum;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SH_W-2:0], pin_b};
        pin_now   = st_q.sync[SYNC_N-1];
        pin_old   = st_q.sync[SYNC_N];
        case (mode)
            DM_FREE:  evt = 1'b1;
            DM_LEVEL: evt = pin_now;
            DM_RISE:  evt = pin_now & ~pin_old;
            DM_FALL:  evt = ~pin_now & pin_old;
            default:  evt = 1'b0;
        endcase
        div_eff = (div_val < ONE) ? ONE : div_val;
        acc_sum = st_q.acc + ACC_W'(ONE);
        pulse   = 1'b0;
        if (run && evt) begin
            if (acc_sum >= {1'b0, div_eff}) begin
                pulse    = 1'b1;
                st_d.acc = acc_sum - {1'b0, div_eff};
            end else begin
                st_d.acc = acc_sum;
            end
        end
        if (acc_clr) st_d.acc = '0;
        step = run & ((pulse & ~ret) | adv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the divider only fires on an input event
    p_pulse_needs_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (evt && run));
    // R4: unity (or smaller) divisor passes every event
    p_unity_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && evt && div_val <= ONE) |-> pulse);
    // R12: no step leaves a stopped slice
    p_no_step_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !step);

endmodule

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             phase,
    input  logic             step,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wval,
    input  logic [CNT_W-1:0] cmp_a_sh,
    input  logic [CNT_W-1:0] cmp_b_sh,
    input  logic [CNT_W-1:0] top_sh,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp_a,
    output logic [CNT_W-1:0] cmp_b,
    output logic             flag
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic [CNT_W-1:0] cmp_a;
        logic [CNT_W-1:0] cmp_b;
        logic [CNT_W-1:0] top;
        logic             flag;
    } core_t;

    core_t st_d, st_q;
    logic  wrap_evt;

    always_comb begin
        st_d     = st_q;
        wrap_evt = 1'b0;
        if (cnt_wr) begin
            st_d.cnt  = cnt_wval;
            st_d.down = 1'b0;
        end else if (step) begin
            if (!phase) begin
                st_d.down = 1'b0;
                if (st_q.cnt >= st_q.top) begin
                    st_d.cnt = '0;
                    wrap_evt = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else if (!st_q.down) begin
                if (st_q.cnt >= st_q.top) begin
                    if (st_q.top == '0) begin
                        st_d.cnt = '0;
                        wrap_evt = 1'b1;
                    end else begin
                        st_d.cnt  = st_q.cnt - ONE;
                        st_d.down = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else begin
                if (st_q.cnt <= ONE) begin
                    st_d.cnt  = '0;
                    st_d.down = 1'b0;
                    wrap_evt  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end
        if (wrap_evt || !run) begin
            st_d.cmp_a = cmp_a_sh;
            st_d.cmp_b = cmp_b_sh;
            st_d.top   = top_sh;
        end
        if (wrap_evt)     st_d.flag = 1'b1;
        else if (irq_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.down  <= 1'b0;
            st_q.cmp_a <= '0;
            st_q.cmp_b <= '0;
            st_q.top   <= '1;
            st_q.flag  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign cmp_a = st_q.cmp_a;
    assign cmp_b = st_q.cmp_b;
    assign flag  = st_q.flag;

    // R2: sawtooth step at the limit lands on zero
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_wr && !phase && st_q.cnt >= st_q.top) |=> (st_q.cnt == '0));
    // R3: phase-correct step at a nonzero limit turns downward
    p_pc_bounce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_wr && phase && !st_q.down && st_q.cnt == st_q.top && st_q.top != '0)
        |=> (st_q.cnt == $past(st_q.cnt) - ONE));
    // R12: no movement without a step or a load
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !cnt_wr) |=> $stable(st_q.cnt));
    // R9: flag holds until cleared
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !irq_clr) |=> st_q.flag);
    // R7: active levels frozen between boundaries while running
    p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap_evt) |=> ($stable(st_q.cmp_a) && $stable(st_q.cmp_b) && $stable(st_q.top)));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic [CNT_W-1:0]           cnt,
    input  logic [NCH-1:0][CNT_W-1:0]  cmp,
    input  logic [NCH-1:0]             inv,
    output logic [NCH-1:0]             wave
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic below;
        assign below    = (cnt < cmp[ch]);
        assign wave[ch] = below ^ inv[ch];
    end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int INT_W   = 8,
    parameter int FRAC_W  = 4,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              pin_b,
    input  logic              phase_adv,
    input  logic              phase_ret,
    output logic              out_a,
    output logic              out_b,
    output logic              irq,
    output logic [CNT_W-1:0]  count
);
    localparam int DIV_W = INT_W + FRAC_W;
    localparam int NCH   = 2;

    ctrl_t            ctrl;
    logic [DIV_W-1:0] div_val;
    logic [CNT_W-1:0] cmp_a_sh, cmp_b_sh, top_sh, cnt_wval;
    logic [CNT_W-1:0] cmp_a_act, cmp_b_act;
    logic             cnt_wr, irq_clr, step, flag;
    logic [NCH-1:0]   wave;

    pwm_regs #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ctrl(ctrl), .div_val(div_val),
        .cmp_a_sh(cmp_a_sh), .cmp_b_sh(cmp_b_sh), .top_sh(top_sh),
        .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .irq_clr(irq_clr)
    );

    pwm_rate_gen #(
        .DIV_W(DIV_W), .FRAC_W(FRAC_W), .SYNC_N(SYNC_N)
    ) u_rate (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .mode(ctrl.mode),
        .div_val(div_val), .pin_b(pin_b), .acc_clr(cnt_wr),
        .adv(phase_adv), .ret(phase_ret), .step(step)
    );

    pwm_cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .phase(ctrl.phase),
        .step(step), .cnt_wr(cnt_wr), .cnt_wval(cnt_wval),
        .cmp_a_sh(cmp_a_sh), .cmp_b_sh(cmp_b_sh), .top_sh(top_sh),
        .irq_clr(irq_clr), .cnt(count), .cmp_a(cmp_a_act),
        .cmp_b(cmp_b_act), .flag(flag)
    );

    pwm_out_stage #(.CNT_W(CNT_W), .NCH(NCH)) u_out (
        .cnt(count),
        .cmp({cmp_b_act, cmp_a_act}),
        .inv({ctrl.inv_b, ctrl.inv_a}),
        .wave(wave)
    );

    assign out_a = wave[0];
    assign out_b = wave[1];
    assign irq   = flag & ctrl.irq_en;

    // R8: the interrupt never rises without its enable
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl.irq_en);

endmodule

// File: tb/tb_pwm_slice.sv
`timescale 1ns/1ps
module tb_pwm_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pin_b = 1'b0;
    logic        phase_adv = 1'b0;
    logic        phase_ret = 1'b0;
    logic        out_a, out_b, irq;
    logic [15:0] count;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pwm_slice dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pin_b(pin_b), .phase_adv(phase_adv),
        .phase_ret(phase_ret), .out_a(out_a), .out_b(out_b), .irq(irq),
        .count(count)
    );

    typedef struct packed {
        logic [11:0] div;
        logic [15:0] top;
        logic [15:0] ca;
        logic [15:0] cb;
        logic        ia;
        logic        ib;
        logic        pc;
        logic [15:0] n;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{12'd16,   16'd9,      16'd3,   16'd7, 1'b0, 1'b0, 1'b0, 16'd25},
        '{12'd32,   16'd9,      16'd3,   16'd7, 1'b0, 1'b0, 1'b0, 16'd25},
        '{12'd24,   16'd5,      16'd2,   16'd4, 1'b1, 1'b0, 1'b0, 16'd30},
        '{12'd16,   16'd4,      16'd2,   16'd3, 1'b0, 1'b1, 1'b1, 16'd13},
        '{12'd40,   16'd7,      16'd0,   16'd8, 1'b0, 1'b0, 1'b1, 16'd50},
        '{12'd4095, 16'd100,    16'd1,   16'd0, 1'b0, 1'b0, 1'b0, 16'd600},
        '{12'd16,   16'hFFFF,   16'd100, 16'd50, 1'b0, 1'b0, 1'b0, 16'd300},
        '{12'd8,    16'd9,      16'd5,   16'd5, 1'b0, 1'b0, 1'b0, 16'd12}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrlw(input bit run, input bit pc, input bit ia,
                                          input bit ib, input int mode, input bit ie);
        return {25'd0, ie, 2'(mode), ib, ia, pc, run};
    endfunction

    // called at a negedge, returns at the negedge after the capturing posedge
    task automatic wr(input int a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int dv, input int top, input int ca, input int cb);
        wr(0, ctrlw(0, 0, 0, 0, 0, 0));
        wr(1, 32'(dv));
        wr(2, {16'(cb), 16'(ca)});
        wr(3, 32'(top));
        wr(5, 32'd0);
    endtask

    task automatic wait_cnt(input int v, input int maxc, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < maxc && !seen; k++) begin
            @(negedge clk);
            if (count == 16'(v)) seen = 1'b1;
        end
    endtask

    function automatic int exp_cnt(input int steps, input int top, input bit pc);
        int p;
        if (!pc) return steps % (top + 1);
        p = steps % (2 * top);
        return (p <= top) ? p : 2 * top - p;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        int mx;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: reset state
        chk("R2 reset count", count, 0);
        chk("R1 reset out_a", out_a, 0);
        chk("R1 reset out_b", out_b, 0);
        chk("R8 reset irq", irq, 0);

        // R2: reset limit is 0xFFFF, reset divisor is 1.0
        wr(0, ctrlw(1, 0, 0, 0, 0, 0));
        cyc(65535);
        chk("R2 reset limit reached", count, 16'hFFFF);
        cyc(1);
        chk("R2 restart after 0xFFFF", count, 0);

        // table of vectors: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            int deff, steps, ec;
            setup(VEC[i].div, VEC[i].top, VEC[i].ca, VEC[i].cb);
            wr(0, ctrlw(1, VEC[i].pc, VEC[i].ia, VEC[i].ib, 0, 0));
            cyc(VEC[i].n);
            deff  = (VEC[i].div < 16) ? 16 : int'(VEC[i].div);
            steps = (16 * int'(VEC[i].n)) / deff;
            ec    = exp_cnt(steps, VEC[i].top, VEC[i].pc);
            chk(VEC[i].pc ? "R3 R4 count" : "R2 R4 count", count, ec);
            chk("R1 out_a", out_a, 32'((ec < int'(VEC[i].ca)) ^ VEC[i].ia));
            chk("R1 out_b", out_b, 32'((ec < int'(VEC[i].cb)) ^ VEC[i].ib));
        end

        // R7: compare update deferred to boundary while running
        setup(16, 9, 3, 0);
        wr(0, ctrlw(1, 0, 0, 0, 0, 0));
        wr(2, {16'd0, 16'd8});
        wait_cnt(5, 12, seen);
        chk("R7 old level before wrap", {seen, out_a}, {1'b1, 1'b0});
        wait_cnt(0, 12, seen);
        wait_cnt(5, 12, seen);
        chk("R7 new level after wrap", {seen, out_a}, {1'b1, 1'b1});
        // R7: limit update deferred
        wr(3, 32'd5);
        wait_cnt(9, 12, seen);
        chk("R7 old limit still reached", seen, 1);
        wait_cnt(0, 12, seen);
        mx = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
        end
        chk("R7 new limit after wrap", mx, 5);

        // R7 R11: stopped slice takes shadows at once, count load
        wr(0, ctrlw(0, 0, 0, 0, 0, 0));
        wr(3, 32'd20);
        wr(2, {16'd0, 16'd4});
        wr(5, 32'd5);
        chk("R11 count load", count, 5);
        chk("R7 immediate level when stopped", out_a, 0);
        wr(5, 32'd7);
        cyc(10);
        chk("R12 stopped hold", count, 7);

        // R5: level-gated counting
        setup(16, 16'hFFFF, 0, 0);
        wr(0, ctrlw(1, 0, 0, 0, 1, 0));
        cyc(20);
        chk("R5 no event while low", count, 0);
        pin_b = 1'b1; cyc(10); pin_b = 1'b0; cyc(6);
        chk("R5 ten high cycles", count, 10);

        // R10: advance inserts a step
        phase_adv = 1'b1; cyc(1); phase_adv = 1'b0; cyc(3);
        chk("R10 advance", count, 11);

        // R6: rising edges with divisor 2.0
        setup(32, 16'hFFFF, 0, 0);
        wr(0, ctrlw(1, 0, 0, 0, 2, 0));
        for (int k = 0; k < 6; k++) begin
            pin_b = 1'b1; cyc(2); pin_b = 1'b0; cyc(2);
        end
        cyc(6);
        chk("R6 rising edges /2", count, 3);

        // R6: falling edges
        setup(16, 16'hFFFF, 0, 0);
        wr(0, ctrlw(1, 0, 0, 0, 3, 0));
        for (int k = 0; k < 4; k++) begin
            pin_b = 1'b1; cyc(3); pin_b = 1'b0; cyc(3);
        end
        cyc(6);
        chk("R6 falling edges", count, 4);

        // R10: retard drops one step
        setup(16, 16'hFFFF, 0, 0);
        wr(0, ctrlw(1, 0, 0, 0, 0, 0));
        cyc(5);
        phase_ret = 1'b1; cyc(1); phase_ret = 1'b0;
        cyc(14);
        chk("R10 retard", count, 19);

        // R8: sawtooth interrupt timing
        setup(16, 4, 0, 0);
        wr(4, 32'd1);
        wr(0, ctrlw(1, 0, 0, 0, 0, 1));
        cyc(4);
        chk("R8 no irq before wrap", {count, irq}, {16'd4, 1'b0});
        cyc(1);
        chk("R8 irq on wrap", {count, irq}, {16'd0, 1'b1});
        wr(0, ctrlw(0, 0, 0, 0, 0, 1));
        // R9: clear semantics
        wr(4, 32'd0);
        chk("R9 zero write keeps flag", irq, 1);
        wr(4, 32'd1);
        chk("R9 one write clears flag", irq, 0);

        // R8: enable gates the output, flag still set
        wr(5, 32'd0);
        wr(0, ctrlw(1, 0, 0, 0, 0, 0));
        cyc(5);
        chk("R8 disabled irq stays low", irq, 0);
        wr(0, ctrlw(0, 0, 0, 0, 0, 1));
        chk("R8 enable exposes flag", irq, 1);

        // R3 R8: phase-correct interrupt at return to zero
        setup(16, 4, 0, 0);
        wr(4, 32'd1);
        wr(0, ctrlw(1, 1, 0, 0, 0, 1));
        cyc(4);
        chk("R3 peak at limit", {count, irq}, {16'd4, 1'b0});
        cyc(3);
        chk("R3 descending no irq", {count, irq}, {16'd1, 1'b0});
        cyc(1);
        chk("R8 phase irq at zero", {count, irq}, {16'd0, 1'b1});

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule